// File: doc/BRIEF.md
# Reconfigurable Johnson Sequence Source

This block is a parameterised shift chain of `LEN` stages used as a stimulus source in low-power built-in self-test. Two mode inputs choose what is fed into the first stage on each step. The chain can be cleared by filling it with zeros, rotated as a plain circular shift register, or run as a twisted-ring (Johnson) counter. In counter mode, consecutive vectors differ in exactly one bit, which keeps input switching at the circuit under test low.

The chain moves only when `step_en` is high. This enable stands in for the slow test clock of a BIST controller. The full `LEN`-bit state drives the parallel output. The last stage is also brought out as a serial tap, so a scan chain can take Johnson code words one bit at a time while the chain rotates.

A typical use has three phases. The chain is zero-filled. It is then stepped once in counter mode to form the next vector. It is then rotated `LEN` times to stream that vector serially, and the rotation leaves the vector unchanged for the next counter step.

Top module: `jcnt_ring_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, all stages read 0 after that edge, whatever the values of `step_en` and the mode inputs.
- R2: When `step_en` is low and `rst` is low, the state is unchanged after the edge, in every mode.
- R3: Zero-fill mode (`loop_mode`=1, `keep_ones`=0): each enabled step moves bit i into bit i+1 and loads 0 into bit 0.
- R4: Rotate mode (`loop_mode`=1, `keep_ones`=1): each enabled step moves bit i into bit i+1 and loads the old bit `LEN`-1 into bit 0.
- R5: Counter mode (`loop_mode`=0, `keep_ones` ignored): each enabled step moves bit i into bit i+1 and loads the inverse of the old bit `LEN`-1 into bit 0.
- R6: In counter mode, starting from all zeros, 2·`LEN` enabled steps pass through 2·`LEN` distinct states and return to all zeros.
- R7: In counter mode, every enabled step changes exactly one bit of `vec_o`.
- R8: In rotate mode, `LEN` enabled steps leave `vec_o` equal to its value before the first of them.
- R9: `serial_o` always equals bit `LEN`-1 of `vec_o`.
- R10: In zero-fill mode, `LEN` enabled steps bring any state to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance enable (test clock qualifier) |
| loop_mode | input | 1 | 1 selects zero-fill or rotate, 0 selects counter |
| keep_ones | input | 1 | With loop_mode=1: 1 rotates, 0 zero-fills |
| vec_o | output | LEN | Parallel state of the chain |
| serial_o | output | 1 | Serial tap of the last stage |

## Verification
The embedded assertions check on every cycle the single-step relations: hold when disabled, the shift with a zero, own-bit or inverted feed in each mode, and the one-bit change of counter steps. Properties over many steps cannot be seen from one clock edge, so only the bench scenarios show them. These are the full 2·`LEN` counter period with all states distinct, the return of a rotation after `LEN` steps, zero-fill reaching zero, and the reset behaviour. The bench sweeps every reachable counter state of a small chain through rotation, hold and zero-fill.

// File: rtl/jcnt_pkg.sv
package jcnt_pkg;
   // Source of the bit loaded into stage 0 on an enabled step
   typedef enum logic [1:0] {
      FEED_ZERO = 2'd0,
      FEED_SAME = 2'd1,
      FEED_FLIP = 2'd2
   } feed_e;
endpackage

// File: rtl/jcnt_feed_dec.sv
module jcnt_feed_dec
   import jcnt_pkg::*;
(
   input  logic  loop_mode,
   input  logic  keep_ones,
   output feed_e feed_sel
);
   always_comb begin
      if (!loop_mode)     feed_sel = FEED_FLIP;
      else if (keep_ones) feed_sel = FEED_SAME;
      else                feed_sel = FEED_ZERO;
   end
endmodule

// File: rtl/jcnt_feed_mux.sv
module jcnt_feed_mux
   import jcnt_pkg::*;
(
   input  feed_e feed_sel,
   input  logic  tail,
   output logic  head
);
   always_comb begin
      unique case (feed_sel)
         FEED_ZERO: head = 1'b0;
         FEED_SAME: head = tail;
         FEED_FLIP: head = ~tail;
         default:   head = 1'b0;
      endcase
   end
endmodule

// File: rtl/jcnt_chain.sv
module jcnt_chain #(
   parameter int LEN = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           adv,
   input  logic           head,
   output logic [LEN-1:0] q
);
   localparam int LAST = LEN - 1;

   generate
      if (LEN < 2) begin : g_bad_len
         $error("jcnt_chain: LEN must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < LEN; gi++) begin : g_stage
         logic d_in;
         if (gi == 0) begin : g_first
            assign d_in = head;
         end else begin : g_rest
            assign d_in = q[gi-1];
         end
         always_ff @(posedge clk) begin
            if (rst)      q[gi] <= 1'b0;
            else if (adv) q[gi] <= d_in;
         end
      end
   endgenerate

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(q));

   // R3 R4 R5 (common part: body shifts by one stage)
   body_shift_chk: assert property (@(posedge clk) disable iff (rst)
      adv |=> q[LAST:1] == $past(q[LAST-1:0]));
endmodule

// File: rtl/jcnt_ring_top.sv
module jcnt_ring_top
   import jcnt_pkg::*;
#(
   parameter int LEN = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           step_en,
   input  logic           loop_mode,
   input  logic           keep_ones,
   output logic [LEN-1:0] vec_o,
   output logic           serial_o
);
   localparam int LAST = LEN - 1;

   feed_e feed_sel;
   logic  head;

   jcnt_feed_dec u_dec (
      .loop_mode (loop_mode),
      .keep_ones (keep_ones),
      .feed_sel  (feed_sel)
   );

   jcnt_feed_mux u_mux (
      .feed_sel (feed_sel),
      .tail     (vec_o[LAST]),
      .head     (head)
   );

   jcnt_chain #(.LEN(LEN)) u_chain (
      .clk  (clk),
      .rst  (rst),
      .adv  (step_en),
      .head (head),
      .q    (vec_o)
   );

   assign serial_o = vec_o[LAST];

   // R3
   zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && loop_mode && !keep_ones) |=> vec_o == {$past(vec_o[LAST-1:0]), 1'b0});

   // R4
   rotate_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && loop_mode && keep_ones) |=> vec_o == {$past(vec_o[LAST-1:0]), $past(vec_o[LAST])});

   // R5
   twisted_feed_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && !loop_mode) |=> vec_o == {$past(vec_o[LAST-1:0]), ~$past(vec_o[LAST])});

   // R7
   single_change_chk: assert property (@(posedge clk) disable iff (rst)
      (step_en && !loop_mode) |=> $countones(vec_o ^ $past(vec_o)) == 1);
endmodule

// File: tb/tb_jcnt_ring_top.sv
module tb_jcnt_ring_top;
   localparam int L = 6;
   localparam logic [L-1:0] MASK = '1;

   logic clk = 1'b0;
   logic rst = 1'b1, step_en = 1'b0, loop_mode = 1'b0, keep_ones = 1'b0;
   logic [L-1:0] vec;
   logic ser;
   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   jcnt_ring_top #(.LEN(L)) dut (
      .clk(clk), .rst(rst), .step_en(step_en), .loop_mode(loop_mode),
      .keep_ones(keep_ones), .vec_o(vec), .serial_o(ser)
   );

   task automatic chk(input bit ok, input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic e, input logic lm, input logic ko);
      @(negedge clk);
      rst = r; step_en = e; loop_mode = lm; keep_ones = ko;
      @(posedge clk);
      #1;
      chk(ser === vec[L-1], "R9", {{(L-1){1'b0}}, ser}, {{(L-1){1'b0}}, vec[L-1]});
   endtask

   function automatic logic [L-1:0] jstate(input int k);
      if (k <= L) return L'((1 << k) - 1);
      return MASK & ~L'((1 << (k - L)) - 1);
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [L-1:0] snap, prev;
      bit seen [0:(1<<L)-1];

      // R1: reset with enable high in counter mode
      cyc(1, 1, 0, 0);
      chk(vec === '0, "R1", vec, '0);
      // R6 R7: full counter period
      for (int i = 0; i < (1 << L); i++) seen[i] = 1'b0;
      seen[0] = 1'b1;
      for (int j = 1; j <= 2 * L; j++) begin
         prev = vec;
         cyc(0, 1, 0, j[0]);
         chk(vec === jstate(j % (2 * L)), "R5", vec, jstate(j % (2 * L)));
         chk($countones(vec ^ prev) == 1, "R7", vec ^ prev, '0);
         if (j < 2 * L) begin
            chk(!seen[vec], "R6", vec, '0);
            seen[vec] = 1'b1;
         end
      end
      chk(vec === '0, "R6", vec, '0);

      // R1: reset from a non-zero state in rotate mode
      cyc(0, 1, 0, 0);
      cyc(0, 1, 0, 0);
      cyc(1, 1, 1, 1);
      chk(vec === '0, "R1", vec, '0);

      // Sweep every counter state through hold, rotation and zero-fill
      for (int k = 0; k < 2 * L; k++) begin
         cyc(1, 0, 0, 0);
         for (int j = 0; j < k; j++) cyc(0, 1, 0, 1);
         chk(vec === jstate(k), "R5", vec, jstate(k));
         snap = vec;
         // R2
         cyc(0, 0, 0, 0); chk(vec === snap, "R2", vec, snap);
         cyc(0, 0, 1, 1); chk(vec === snap, "R2", vec, snap);
         cyc(0, 0, 1, 0); chk(vec === snap, "R2", vec, snap);
         // R4 R8
         for (int j = 0; j < L; j++) begin
            prev = vec;
            cyc(0, 1, 1, 1);
            chk(vec === {prev[L-2:0], prev[L-1]}, "R4", vec, {prev[L-2:0], prev[L-1]});
         end
         chk(vec === snap, "R8", vec, snap);
         // R3 R10
         for (int j = 0; j < L; j++) begin
            prev = vec;
            cyc(0, 1, 1, 0);
            chk(vec === {prev[L-2:0], 1'b0}, "R3", vec, {prev[L-2:0], 1'b0});
         end
         chk(vec === '0, "R10", vec, '0);
      end

      finish_run();
   end
endmodule